// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block gives two processor ports a shared set of eight lock flags, which they use to take turns on a common resource. A port claims a flag by writing 0 to it and gives it back by writing 1. The port that claims a free flag first becomes its owner, and from then on only the owner can change that flag. A claim from the other side is not lost: it waits in that side's request latch. When the owner releases the flag, ownership passes straight to the waiting side without any further write.

Each port reads the flag state as it sees it. The single bit is spread across the whole data bus, so a read returns all zeros when that side holds the flag and all ones otherwise. The read value is captured when a read begins and is held until the port ends the read, so the other side cannot change the data partway through a read.

The usual sequence is to write 0 and then read back. The read tells the processor whether it got the flag or must wait. Everything is synchronous to one clock. If both sides claim the same free flag in the same cycle, the left side wins.

Top module: `sem_unit`

## Requirements
- R1: The flag is picked by address bits [2:0], giving eight flags. The higher address bits have no effect on writes or reads. A write to one flag leaves the other seven unchanged.
- R2: A write of 0 to a free flag makes the writer the owner, so it reads 0 while the other side reads 1. If both sides write 0 to a free flag in the same cycle, the left side becomes the owner and the right side's claim becomes pending.
- R3: A write samples only data bit 0. Bits [DATA_W-1:1] have no effect.
- R4: While a side owns a flag, writes of 0 or 1 from the other side do not change who owns it.
- R5: A write of 0 from the non-owning side sets that side's request latch. That side keeps reading 1 while the request is pending. A later write of 1 from the same side clears the request.
- R6: When the owner writes 1 and the other side has a request pending, the other side becomes the owner in the same cycle. If no request is pending, the flag becomes free and both sides read 1.
- R7: A port is reading while select and output enable are high and write is low. On the first clock edge of a read, the port captures its current view of the addressed flag. From the next cycle on, that value appears on every bit of the port's read data: all ones when the flag is free or owned by the other side, all zeros when the port owns it.
- R8: The read data holds the captured value for as long as the read continues, even if the flag changes underneath it. A new value is captured only after the read ends and a new one begins.
- R9: After reset all flags are free, no requests are pending, and both read data buses are all ones.
- R10: A write of 1 from a side that neither owns the flag nor has a request pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel | input | 1 | Left port semaphore select |
| l_oe | input | 1 | Left port output enable |
| l_wr | input | 1 | Left port write strobe (1 = write) |
| l_addr | input | ADDR_W | Left port address; bits [2:0] pick the flag |
| l_wdata | input | DATA_W | Left port write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left port read data, flag bit replicated |
| r_sel | input | 1 | Right port semaphore select |
| r_oe | input | 1 | Right port output enable |
| r_wr | input | 1 | Right port write strobe (1 = write) |
| r_addr | input | ADDR_W | Right port address; bits [2:0] pick the flag |
| r_wdata | input | DATA_W | Right port write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right port read data, flag bit replicated |

## Verification
Every flag is driven through all 64 sequences of three writes. Each write comes from either side with either bit value, with random upper address bits and random upper data bits. After each sequence, both sides read the flag and one neighbouring flag. These reads distinguish claiming, locking out the other side, pending requests, handover, withdrawing a request, and a release with nothing waiting. They also show whether the upper address bits, the upper data bits, or a write to the wrong flag leak through. Directed cases cover three further points. The first is a same-cycle claim by both sides. The second is a handover that happens while the receiving side is in the middle of a read. The held value must stay unchanged until that read ends. The third is a write of 1 from a side with no stake in the flag.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_t;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_we,
  input  logic l_bit,
  input  logic r_we,
  input  logic r_bit,
  output logic l_own,
  output logic r_own,
  output logic l_pend,
  output logic r_pend
);
  holder_t holder_q, holder_d;
  logic    pend_l_q, pend_l_d;
  logic    pend_r_q, pend_r_d;
  logic    upd_en;
  logic    l_want, r_want;

  // Request each side holds after this cycle's write (a write replaces the latch).
  assign l_want = l_we ? ~l_bit : pend_l_q;
  assign r_want = r_we ? ~r_bit : pend_r_q;
  assign upd_en = l_we | r_we;

  always_comb begin
    holder_d = holder_q;
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    unique case (holder_q)
      HOLD_NONE: begin
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
        if (l_we && !l_bit) begin
          holder_d = HOLD_LEFT;
          pend_r_d = r_we && !r_bit;
        end else if (r_we && !r_bit) begin
          holder_d = HOLD_RIGHT;
        end
      end
      HOLD_LEFT: begin
        pend_l_d = 1'b0;
        if (l_we && l_bit) begin
          holder_d = r_want ? HOLD_RIGHT : HOLD_NONE;
          pend_r_d = 1'b0;
        end else begin
          pend_r_d = r_want;
        end
      end
      HOLD_RIGHT: begin
        pend_r_d = 1'b0;
        if (r_we && r_bit) begin
          holder_d = l_want ? HOLD_LEFT : HOLD_NONE;
          pend_l_d = 1'b0;
        end else begin
          pend_l_d = l_want;
        end
      end
      default: begin
        holder_d = HOLD_NONE;
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holder_q <= HOLD_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else if (upd_en) begin
      holder_q <= holder_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign l_own  = (holder_q == HOLD_LEFT);
  assign r_own  = (holder_q == HOLD_RIGHT);
  assign l_pend = pend_l_q;
  assign r_pend = pend_r_q;
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic              view_bit,
  output logic [DATA_W-1:0] rdata
);
  logic act_q;
  logic cap_q, cap_d;
  logic start;

  assign start = rd_act & ~act_q;

  always_comb begin
    cap_d = cap_q;
    if (start) cap_d = view_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cap_q <= 1'b1;
    end else begin
      act_q <= rd_act;
      if (start) cap_q <= cap_d;
    end
  end

  assign rdata = {DATA_W{cap_q}};
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
  parameter int N_FLAGS = 8,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_oe,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_oe,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int FLAG_AW = $clog2(N_FLAGS);

  logic               srst_n;
  logic               l_wen, r_wen;
  logic               l_rd, r_rd;
  logic [FLAG_AW-1:0] l_idx, r_idx;
  logic [N_FLAGS-1:0] l_own, r_own, l_pend, r_pend;
  logic [N_FLAGS-1:0] l_view, r_view;
  logic               unused_hi;

  sem_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(srst_n)
  );

  assign l_idx = l_addr[FLAG_AW-1:0];
  assign r_idx = r_addr[FLAG_AW-1:0];
  assign l_wen = l_sel & l_wr;
  assign r_wen = r_sel & r_wr;
  assign l_rd  = l_sel & l_oe & ~l_wr;
  assign r_rd  = r_sel & r_oe & ~r_wr;

  assign unused_hi = ^{l_addr[ADDR_W-1:FLAG_AW], r_addr[ADDR_W-1:FLAG_AW],
                       l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  for (genvar k = 0; k < N_FLAGS; k++) begin : g_flag
    sem_flag_cell u_cell (
      .clk   (clk),
      .rst_n (srst_n),
      .l_we  (l_wen && (l_idx == FLAG_AW'(k))),
      .l_bit (l_wdata[0]),
      .r_we  (r_wen && (r_idx == FLAG_AW'(k))),
      .r_bit (r_wdata[0]),
      .l_own (l_own[k]),
      .r_own (r_own[k]),
      .l_pend(l_pend[k]),
      .r_pend(r_pend[k])
    );
  end

  assign l_view = ~l_own;
  assign r_view = ~r_own;

  sem_read_port #(.DATA_W(DATA_W)) u_lrd (
    .clk     (clk),
    .rst_n   (srst_n),
    .rd_act  (l_rd),
    .view_bit(l_view[l_idx]),
    .rdata   (l_rdata)
  );

  sem_read_port #(.DATA_W(DATA_W)) u_rrd (
    .clk     (clk),
    .rst_n   (srst_n),
    .rd_act  (r_rd),
    .view_bit(r_view[r_idx]),
    .rdata   (r_rdata)
  );
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int N_FLAGS = 8,
  parameter int FLAG_AW = 3,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_wen,
  input logic               r_wen,
  input logic [FLAG_AW-1:0] l_idx,
  input logic [FLAG_AW-1:0] r_idx,
  input logic               l_bit,
  input logic               r_bit,
  input logic [N_FLAGS-1:0] l_own,
  input logic [N_FLAGS-1:0] r_own,
  input logic [N_FLAGS-1:0] l_pend,
  input logic [N_FLAGS-1:0] r_pend,
  input logic               l_rd,
  input logic               r_rd,
  input logic [DATA_W-1:0]  l_rdata,
  input logic [DATA_W-1:0]  r_rdata
);
  for (genvar k = 0; k < N_FLAGS; k++) begin : g_k
    a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_own[k] && r_own[k]));

    a_r4_left_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (l_own[k] && !(l_wen && l_idx == FLAG_AW'(k) && l_bit)) |=> l_own[k]);

    a_r4_right_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (r_own[k] && !(r_wen && r_idx == FLAG_AW'(k) && r_bit)) |=> r_own[k]);

    a_r5_left_pend_waits: assert property (@(posedge clk) disable iff (!rst_n)
      l_pend[k] |-> r_own[k]);

    a_r5_right_pend_waits: assert property (@(posedge clk) disable iff (!rst_n)
      r_pend[k] |-> l_own[k]);

    a_r6_pass_to_right: assert property (@(posedge clk) disable iff (!rst_n)
      (l_own[k] && l_wen && l_idx == FLAG_AW'(k) && l_bit && r_pend[k]
       && !(r_wen && r_idx == FLAG_AW'(k))) |=> r_own[k]);

    a_r6_pass_to_left: assert property (@(posedge clk) disable iff (!rst_n)
      (r_own[k] && r_wen && r_idx == FLAG_AW'(k) && r_bit && l_pend[k]
       && !(l_wen && l_idx == FLAG_AW'(k))) |=> l_own[k]);
  end

  a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && $past(l_rd)) |=> $stable(l_rdata));

  a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd && $past(r_rd)) |=> $stable(r_rdata));
endmodule

bind sem_unit sem_unit_chk #(
  .N_FLAGS(N_FLAGS),
  .FLAG_AW(FLAG_AW),
  .DATA_W (DATA_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .l_wen  (l_wen),
  .r_wen  (r_wen),
  .l_idx  (l_idx),
  .r_idx  (r_idx),
  .l_bit  (l_wdata[0]),
  .r_bit  (r_wdata[0]),
  .l_own  (l_own),
  .r_own  (r_own),
  .l_pend (l_pend),
  .r_pend (r_pend),
  .l_rd   (l_rd),
  .r_rd   (r_rd),
  .l_rdata(l_rdata),
  .r_rdata(r_rdata)
);

// File: tb/test_sem_unit.sv
module test_sem_unit;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic              clk;
  logic              rst_n;
  logic              l_sel, l_oe, l_wr, r_sel, r_oe, r_wr;
  logic [ADDR_W-1:0] l_addr, r_addr;
  logic [DATA_W-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  int checks;
  int failures;
  bit done;

  // Model: 0 free, 1 left owns, 2 right owns
  int own [8];
  bit pl  [8];
  bit pr  [8];

  sem_unit #(.N_FLAGS(8), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sem_unit (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_oe(l_oe), .l_wr(l_wr), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_oe(r_oe), .r_wr(r_wr), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int k);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'($urandom);
    a[2:0] = 3'(k);
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] mk_data(input bit b);
    logic [DATA_W-1:0] d;
    d = DATA_W'($urandom);
    d[0] = b;
    return d;
  endfunction

  // Model update for a single-side write (R2 R4 R5 R6 R10)
  function automatic void model_wr(input bit right, input int k, input bit b);
    if (!right) begin
      if (own[k] == 0) begin
        if (!b) own[k] = 1;
      end else if (own[k] == 1) begin
        if (b) begin own[k] = pr[k] ? 2 : 0; pr[k] = 0; end
      end else pl[k] = !b;
    end else begin
      if (own[k] == 0) begin
        if (!b) own[k] = 2;
      end else if (own[k] == 2) begin
        if (b) begin own[k] = pl[k] ? 1 : 0; pl[k] = 0; end
      end else pr[k] = !b;
    end
  endfunction

  function automatic logic [DATA_W-1:0] exp_view(input bit right, input int k);
    return (own[k] == (right ? 2 : 1)) ? '0 : ONES;
  endfunction

  task automatic do_wr(input bit right, input int k, input bit b);
    @(negedge clk);
    if (!right) begin
      l_sel = 1; l_wr = 1; l_oe = $urandom_range(0, 1);
      l_addr = mk_addr(k); l_wdata = mk_data(b);
    end else begin
      r_sel = 1; r_wr = 1; r_oe = $urandom_range(0, 1);
      r_addr = mk_addr(k); r_wdata = mk_data(b);
    end
    @(negedge clk);
    l_sel = 0; l_wr = 0; l_oe = 0; r_sel = 0; r_wr = 0; r_oe = 0;
    model_wr(right, k, b);
  endtask

  task automatic do_rd(input bit right, input int k, output logic [DATA_W-1:0] v);
    @(negedge clk);
    if (!right) begin l_sel = 1; l_oe = 1; l_wr = 0; l_addr = mk_addr(k); end
    else        begin r_sel = 1; r_oe = 1; r_wr = 0; r_addr = mk_addr(k); end
    @(negedge clk);
    v = right ? r_rdata : l_rdata;
    l_sel = 0; l_oe = 0; r_sel = 0; r_oe = 0;
  endtask

  task automatic rd_chk(input string tag, input bit right, input int k);
    logic [DATA_W-1:0] v;
    do_rd(right, k, v);
    chk(tag, v, exp_view(right, k));
  endtask

  // Watchdog
  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v;
    checks = 0; failures = 0; done = 0;
    l_sel = 0; l_oe = 0; l_wr = 0; l_addr = '0; l_wdata = '0;
    r_sel = 0; r_oe = 0; r_wr = 0; r_addr = '0; r_wdata = '0;
    for (int k = 0; k < 8; k++) begin own[k] = 0; pl[k] = 0; pr[k] = 0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk("R9 left idle rdata", l_rdata, ONES);
    chk("R9 right idle rdata", r_rdata, ONES);
    for (int k = 0; k < 8; k++) begin
      rd_chk("R9 left flag free", 0, k);
      rd_chk("R9 right flag free", 1, k);
    end

    // R10 / R2 / R4 / R5 / R6 directed on flag 6
    do_wr(0, 6, 1);
    rd_chk("R10 left release on free flag", 0, 6);
    do_wr(1, 6, 0);
    rd_chk("R2 right claims", 1, 6);
    rd_chk("R2 left sees other owner", 0, 6);
    do_wr(0, 6, 1);
    rd_chk("R10 stray release keeps owner", 1, 6);
    do_wr(0, 6, 0);
    rd_chk("R5 pending left reads one", 0, 6);
    rd_chk("R4 owner unchanged by claim", 1, 6);
    do_wr(0, 6, 1);
    do_wr(1, 6, 1);
    rd_chk("R5 withdrawn request not granted", 0, 6);
    rd_chk("R6 release with none pending frees", 1, 6);

    // R2: same-cycle claim, left wins, right pending
    @(negedge clk);
    l_sel = 1; l_wr = 1; l_addr = mk_addr(5); l_wdata = mk_data(0);
    r_sel = 1; r_wr = 1; r_addr = mk_addr(5); r_wdata = mk_data(0);
    @(negedge clk);
    l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
    own[5] = 1; pr[5] = 1;
    rd_chk("R2 tie left owns", 0, 5);
    rd_chk("R2 tie right waits", 1, 5);
    do_wr(0, 5, 1);
    rd_chk("R6 tie loser receives flag", 1, 5);
    do_wr(1, 5, 1);

    // R7 / R8: handover in the middle of a left read
    do_wr(1, 3, 0);
    do_wr(0, 3, 0);
    @(negedge clk);
    l_sel = 1; l_oe = 1; l_wr = 0; l_addr = mk_addr(3);
    @(negedge clk);
    chk("R7 read captured ones", l_rdata, ONES);
    r_sel = 1; r_wr = 1; r_addr = mk_addr(3); r_wdata = mk_data(1);
    @(negedge clk);
    r_sel = 0; r_wr = 0;
    model_wr(1, 3, 1);
    chk("R8 held during handover", l_rdata, ONES);
    repeat (2) @(negedge clk);
    chk("R8 still held", l_rdata, ONES);
    l_sel = 0; l_oe = 0;
    @(negedge clk);
    rd_chk("R6 R7 reread shows new owner zeros", 0, 3);
    do_wr(0, 3, 1);

    // Sweep: every flag, all 64 three-write sequences (R1 R2 R3 R4 R5 R6 R10)
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < 64; s++) begin
        for (int i = 0; i < 3; i++) begin
          int op;
          op = (s >> (2 * i)) & 3;
          do_wr(op[1], k, op[0]);
        end
        rd_chk("R2/R4/R5/R6/R10 sweep left", 0, k);
        rd_chk("R2/R4/R5/R6/R10 sweep right", 1, k);
        rd_chk("R1 R3 neighbour left", 0, (k + 1) % 8);
        rd_chk("R1 R3 neighbour right", 1, (k + 7) % 8);
      end
      // return flag to free
      if (own[k] == 1) do_wr(0, k, 1);
      if (own[k] == 2) do_wr(1, k, 1);
      if (own[k] == 1) do_wr(0, k, 1);
      rd_chk("R6 sweep cleanup free", 0, k);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule